// File: doc/BRIEF.md
# Binary-Weight Pointwise Convolution Array

This block computes a 1x1 convolution layer as a blocked matrix product. The weights are single bits and the input activations are unsigned 4-bit values. On each accepted input beat, one vector of `LANES_IN` (default 32) input channels at one pixel is combined with a `LANES_OUT` x `LANES_IN` block of binary weights. That produces `LANES_OUT` partial dot products. The partial sums stay in a per-output-lane register file across every input-channel block of that pixel (output stationary). Only finished sums leave the block, as one wide streaming beat per pixel and output-channel block.

The host works in this order:
1. Preload the weight store through a row-write port.
2. Program the run-time sizes: total input channels, total output channels, width and height.
3. Pulse `start`.

After `start`, a producer streams activation vectors. For each pixel it walks the output-channel blocks, and inside each output block it walks the input-channel blocks in ascending order. The same pixel's input vectors are therefore sent once per output block. Both stream edges use valid/ready, and the array stalls without losing data while the consumer is not ready.

Top module: `bwconv_array`

## Requirements
- R1: When reset is released, `out_valid`, `in_ready` and `busy` are all 0.
- R2: While no run is active, `in_ready` stays 0. Input beats offered in that state are not consumed and produce no output.
- R3: For each weight bit, 1 adds the activation and 0 subtracts it. Activations are unsigned. Each result is the two's complement sum taken modulo 2^`ACC_W` (13 bits by default).
- R4: The register file accumulates across all input-channel blocks of a pixel and output block. It then emits exactly one output beat. Bits `[o*ACC_W +: ACC_W]` of that beat carry output channel `ocb*LANES_OUT + o`.
- R5: Input beats arrive per pixel, then per output block, then per input block in ascending order. Bits `[i*4 +: 4]` of a beat carry input channel `icb*LANES_IN + i`.
- R6: Weight block address `ocb*n_icb + icb` holds one `LANES_IN`-bit row per output lane. Bit `i` of row `o` is the weight from input channel `icb*LANES_IN+i` to output channel `ocb*LANES_OUT+o`.
- R7: Input lanes whose channel index is at or beyond the input channel total add zero, whatever data they carry.
- R8: Output lanes whose channel index is at or beyond the output channel total are emitted as zero.
- R9: While `out_valid` is 1 and `out_ready` is 0:
  - `out_valid` and `out_data` hold unchanged.
  - `in_ready` is 0.
- R10: `busy` rises in the cycle after an idle `start` and stays high until the last output beat is accepted. A `start` pulse while busy is ignored.
- R11: A run accepts exactly width x height x n_ocb x n_icb input beats. After that, `in_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_we | input | 1 | Weight row write strobe |
| wt_blk | input | BLK_W | Weight block address |
| wt_lane | input | OLANE_W | Output lane whose row is written |
| wt_row | input | LANES_IN | Weight bits for that lane, one per input lane |
| cfg_ic_total | input | CH_W | Total input channels |
| cfg_oc_total | input | CH_W | Total output channels |
| cfg_width | input | DIM_W | Feature map width |
| cfg_height | input | DIM_W | Feature map height |
| start | input | 1 | Begin a run (taken only when idle) |
| busy | output | 1 | Run in progress |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Input vector accepted |
| in_data | input | LANES_IN*ACT_W | Activation vector |
| out_valid | output | 1 | Output sums valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | LANES_OUT*ACC_W | Finished sums for one output block |

## Verification
The arithmetic is first tried with directed patterns:
- All-one weights with saturated activations give the largest positive sum.
- All-zero weights with random data expose a swapped sign.
- A 464-channel saturated run exposes accumulator wrap.

Random multi-block runs with several pixels test the remaining ordering rules:
- Block addressing, lane packing and the reset of the accumulator at each new output block are each separated from the others.
- Channel totals that are not multiples of the lane count, with garbage in the unused input lanes, separate input masking from output masking.

A final run with random input gaps and a 50% consumer-ready rate checks that stalls hold data and never lose or repeat a beat. That run also places a stray `start` in mid-run.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef struct packed {
    logic first_ic;
    logic last_ic;
  } beat_tag_t;

  function automatic int unsigned blocks_for(int unsigned count, int unsigned lanes);
    return (count + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/bwc_wbank.sv
module bwc_wbank #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bwc_lane.sv
module bwc_lane #(
  parameter int LANES_IN = 32,
  parameter int ACT_W    = 4,
  parameter int ACC_W    = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      first,
  input  logic [LANES_IN*ACT_W-1:0] act,
  input  logic [LANES_IN-1:0]       wrow,
  output logic [ACC_W-1:0]          acc_nxt
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] dot;
  logic [ACC_W-1:0] term;

  always_comb begin
    dot  = '0;
    term = '0;
    for (int i = 0; i < LANES_IN; i++) begin
      term = ACC_W'(act[i*ACT_W +: ACT_W]);
      if (wrow[i]) dot = dot + term;
      else         dot = dot - term;
    end
    acc_nxt = (first ? '0 : acc_q) + dot;
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
#(
  parameter int LANES_IN  = 32,
  parameter int LANES_OUT = 32,
  parameter int CH_W      = 10,
  parameter int DIM_W     = 8,
  parameter int BLK_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             idle,
  input  logic [CH_W-1:0]  cfg_ic_total,
  input  logic [CH_W-1:0]  cfg_oc_total,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic             adv,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             feeding,
  output logic [BLK_W-1:0] rd_addr,
  output beat_tag_t        tag,
  output logic [CH_W-1:0]  ic_rem,
  output logic [CH_W-1:0]  oc_rem
);

  localparam int PIX_W = 2 * DIM_W;

  logic [CH_W-1:0]  ic_tot, oc_tot, n_icb, n_ocb;
  logic [CH_W-1:0]  icb, ocb, ic_base, oc_base;
  logic [PIX_W-1:0] pix, npix;
  logic [BLK_W-1:0] wblk;
  logic             feeding_q;
  logic             in_fire, last_ic, last_oc, last_pix;

  assign in_ready = feeding_q && adv;
  assign in_fire  = in_valid && in_ready;
  assign last_ic  = (icb == n_icb - 1'b1);
  assign last_oc  = (ocb == n_ocb - 1'b1);
  assign last_pix = (pix == npix - 1'b1);

  assign feeding      = feeding_q;
  assign rd_addr      = wblk;
  assign tag.first_ic = (icb == '0);
  assign tag.last_ic  = last_ic;
  assign ic_rem       = ic_tot - ic_base;
  assign oc_rem       = oc_tot - oc_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      feeding_q <= 1'b0;
      ic_tot <= '0; oc_tot <= '0; n_icb <= '0; n_ocb <= '0;
      icb <= '0; ocb <= '0; ic_base <= '0; oc_base <= '0;
      pix <= '0; npix <= '0; wblk <= '0;
    end else if (start && idle) begin
      ic_tot  <= cfg_ic_total;
      oc_tot  <= cfg_oc_total;
      n_icb   <= CH_W'(blocks_for(32'(cfg_ic_total), LANES_IN));
      n_ocb   <= CH_W'(blocks_for(32'(cfg_oc_total), LANES_OUT));
      npix    <= PIX_W'(cfg_width) * PIX_W'(cfg_height);
      icb <= '0; ocb <= '0; ic_base <= '0; oc_base <= '0;
      pix <= '0; wblk <= '0;
      feeding_q <= (cfg_ic_total != '0) && (cfg_oc_total != '0) &&
                   (cfg_width != '0) && (cfg_height != '0);
    end else if (in_fire) begin
      if (last_ic) begin
        icb     <= '0;
        ic_base <= '0;
        if (last_oc) begin
          ocb     <= '0;
          oc_base <= '0;
          wblk    <= '0;
          if (last_pix) feeding_q <= 1'b0;
          else          pix <= pix + 1'b1;
        end else begin
          ocb     <= ocb + 1'b1;
          oc_base <= oc_base + CH_W'(LANES_OUT);
          wblk    <= wblk + 1'b1;
        end
      end else begin
        icb     <= icb + 1'b1;
        ic_base <= ic_base + CH_W'(LANES_IN);
        wblk    <= wblk + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bwconv_array.sv
module bwconv_array
  import bwc_pkg::*;
#(
  parameter int LANES_IN   = 32,
  parameter int LANES_OUT  = 32,
  parameter int ACT_W      = 4,
  parameter int ACC_W      = 13,
  parameter int CH_W       = 10,
  parameter int DIM_W      = 8,
  parameter int WBLK_DEPTH = 64,
  localparam int BLK_W   = $clog2(WBLK_DEPTH),
  localparam int OLANE_W = $clog2(LANES_OUT),
  localparam int IN_W    = LANES_IN * ACT_W,
  localparam int OUT_W   = LANES_OUT * ACC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wt_we,
  input  logic [BLK_W-1:0]   wt_blk,
  input  logic [OLANE_W-1:0] wt_lane,
  input  logic [LANES_IN-1:0] wt_row,
  input  logic [CH_W-1:0]    cfg_ic_total,
  input  logic [CH_W-1:0]    cfg_oc_total,
  input  logic [DIM_W-1:0]   cfg_width,
  input  logic [DIM_W-1:0]   cfg_height,
  input  logic               start,
  output logic               busy,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IN_W-1:0]    in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data
);

  logic             adv, feeding, in_fire;
  logic [BLK_W-1:0] rd_addr;
  beat_tag_t        tag;
  logic [CH_W-1:0]  ic_rem, oc_rem;

  logic [IN_W-1:0]      act_m;
  logic [LANES_OUT-1:0] omask;

  logic                 s1_v, s1_first, s1_last;
  logic [IN_W-1:0]      s1_act;
  logic [LANES_OUT-1:0] s1_omask;

  logic [LANES_IN-1:0] wrow     [LANES_OUT];
  logic [ACC_W-1:0]    lane_sum [LANES_OUT];

  assign adv     = !out_valid || out_ready;
  assign busy    = feeding || s1_v || out_valid;
  assign in_fire = in_valid && in_ready;

  bwc_seq #(
    .LANES_IN(LANES_IN), .LANES_OUT(LANES_OUT), .CH_W(CH_W),
    .DIM_W(DIM_W), .BLK_W(BLK_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .idle(!busy),
    .cfg_ic_total(cfg_ic_total), .cfg_oc_total(cfg_oc_total),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .adv(adv), .in_valid(in_valid), .in_ready(in_ready),
    .feeding(feeding), .rd_addr(rd_addr), .tag(tag),
    .ic_rem(ic_rem), .oc_rem(oc_rem)
  );

  // Lane masks for partial channel blocks
  always_comb begin
    for (int i = 0; i < LANES_IN; i++)
      act_m[i*ACT_W +: ACT_W] = (CH_W'(i) < ic_rem) ? in_data[i*ACT_W +: ACT_W] : '0;
    for (int o = 0; o < LANES_OUT; o++)
      omask[o] = (CH_W'(o) < oc_rem);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_act   <= '0;
      s1_omask <= '0;
    end else if (adv) begin
      s1_v <= in_fire;
      if (in_fire) begin
        s1_first <= tag.first_ic;
        s1_last  <= tag.last_ic;
        s1_act   <= act_m;
        s1_omask <= omask;
      end
    end
  end

  for (genvar o = 0; o < LANES_OUT; o++) begin : g_lane
    bwc_wbank #(.DEPTH(WBLK_DEPTH), .WIDTH(LANES_IN)) u_bank (
      .clk(clk),
      .we(wt_we && (wt_lane == OLANE_W'(o))),
      .waddr(wt_blk), .wdata(wt_row),
      .re(adv), .raddr(rd_addr), .rdata(wrow[o])
    );

    bwc_lane #(.LANES_IN(LANES_IN), .ACT_W(ACT_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst(rst),
      .en(s1_v && adv), .first(s1_first),
      .act(s1_act), .wrow(wrow[o]),
      .acc_nxt(lane_sum[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= s1_v && s1_last;
      if (s1_v && s1_last) begin
        for (int o = 0; o < LANES_OUT; o++)
          out_data[o*ACC_W +: ACC_W] <= s1_omask[o] ? lane_sum[o] : '0;
      end
    end
  end

endmodule

// File: rtl/bwconv_array_chk.sv
module bwconv_array_chk #(
  parameter int OUT_W = 416
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!out_valid && !busy && !in_ready)); // R1
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst) !busy |-> !in_ready); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |-> !in_ready); // R9
  AST_OUT_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst) out_valid |-> busy); // R10

endmodule

bind bwconv_array bwconv_array_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/bwconv_array_tb.sv
module bwconv_array_tb;

  localparam int LI = 32, LO = 32, AW = 4, CW = 13, CHW = 10, DW = 8, WD = 64;
  localparam int BW = $clog2(WD), OW = $clog2(LO);

  logic clk = 1'b0, rst = 1'b1;
  logic wt_we = 1'b0;
  logic [BW-1:0] wt_blk = '0;
  logic [OW-1:0] wt_lane = '0;
  logic [LI-1:0] wt_row = '0;
  logic [CHW-1:0] cfg_ic_total = '0, cfg_oc_total = '0;
  logic [DW-1:0] cfg_width = '0, cfg_height = '0;
  logic start = 1'b0, busy;
  logic in_valid = 1'b0, in_ready;
  logic [LI*AW-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [LO*CW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [LI-1:0] wref [WD][LO];
  logic [AW-1:0] aref [8][15][LI];

  always #5 clk = ~clk;

  bwconv_array #(
    .LANES_IN(LI), .LANES_OUT(LO), .ACT_W(AW), .ACC_W(CW),
    .CH_W(CHW), .DIM_W(DW), .WBLK_DEPTH(WD)
  ) u_dut (
    .clk(clk), .rst(rst), .wt_we(wt_we), .wt_blk(wt_blk), .wt_lane(wt_lane),
    .wt_row(wt_row), .cfg_ic_total(cfg_ic_total), .cfg_oc_total(cfg_oc_total),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .start(start), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Reference sum: weight bit 1 adds, 0 subtracts, modulo 2^CW (R3, R7, R8)
  function automatic int exp_lane(int p, int ob, int o, int ic, int oc, int nicb);
    int s;
    s = 0;
    if (ob*LO + o >= oc) return 0;
    for (int ib = 0; ib < nicb; ib++)
      for (int i = 0; i < LI; i++)
        if (ib*LI + i < ic)
          s += wref[ob*nicb + ib][o][i] ? int'(aref[p][ib][i]) : -int'(aref[p][ib][i]);
    return s & ((1 << CW) - 1);
  endfunction

  task automatic run_case(input int ic, input int oc, input int wd, input int ht,
                          input int wmode, input int amode, input int vpct, input int rpct,
                          input string tag, input bit poke);
    int nicb, nocb, npix, nbeats, nout;
    int sent, got, sp, sob, sib, gp, gob, e;
    bit fired, stall, poked;
    logic [LO*CW-1:0] held;
    logic [LI-1:0] row;
    nicb = (ic + LI - 1) / LI;
    nocb = (oc + LO - 1) / LO;
    npix = wd * ht;
    nbeats = npix * nocb * nicb;
    nout = npix * nocb;
    sent = 0; got = 0; sp = 0; sob = 0; sib = 0; gp = 0; gob = 0;
    fired = 0; stall = 0; poked = 0; held = '0;
    // Weight preload, block address ocb*nicb+icb, row per output lane (R6)
    for (int b = 0; b < nocb*nicb; b++)
      for (int o = 0; o < LO; o++) begin
        row = (wmode == 1) ? '1 : (wmode == 2) ? '0 : LI'($urandom);
        wref[b][o] = row;
        @(negedge clk);
        wt_we = 1'b1; wt_blk = BW'(b); wt_lane = OW'(o); wt_row = row;
      end
    @(negedge clk);
    wt_we = 1'b0;
    for (int p = 0; p < npix; p++)
      for (int ib = 0; ib < nicb; ib++)
        for (int i = 0; i < LI; i++)
          aref[p][ib][i] = (amode == 1) ? 4'd15 : AW'($urandom % 16);
    cfg_ic_total = CHW'(ic); cfg_oc_total = CHW'(oc);
    cfg_width = DW'(wd); cfg_height = DW'(ht);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 chk(busy == 1'b1, "R10", busy, 1);
    while (got < nout) begin
      @(negedge clk);
      if (fired) begin in_valid = 1'b0; fired = 0; end
      start = 1'b0;
      cfg_ic_total = CHW'(ic);
      if (poke && !poked && sent == 2) begin
        start = 1'b1; cfg_ic_total = CHW'(LI); poked = 1; // R10 stray start while busy
      end
      if (!in_valid && sent < nbeats && ($urandom % 100) < vpct) begin
        // Input lane i carries channel sib*LI+i; unused lanes get garbage (R5, R7)
        for (int i = 0; i < LI; i++)
          in_data[i*AW +: AW] = (sib*LI + i < ic) ? aref[sp][sib][i] : AW'($urandom % 16);
        in_valid = 1'b1;
      end
      out_ready = (($urandom % 100) < rpct);
      #1;
      if (stall) chk(out_valid == 1'b1 && out_data == held, "R9", longint'(out_data[CW-1:0]), longint'(held[CW-1:0]));
      stall = out_valid && !out_ready;
      held = out_data;
      if (stall) chk(in_ready == 1'b0, "R9", in_ready, 0);
      if (in_valid && in_ready) begin
        fired = 1; sent++;
        if (sib == nicb - 1) begin
          sib = 0;
          if (sob == nocb - 1) begin sob = 0; sp++; end
          else sob++;
        end else sib++;
      end
      if (out_valid && out_ready) begin
        for (int o = 0; o < LO; o++) begin
          e = exp_lane(gp, gob, o, ic, oc, nicb);
          chk(out_data[o*CW +: CW] == CW'(e), (gob*LO + o >= oc) ? "R8" : tag,
              longint'(out_data[o*CW +: CW]), longint'(e));
        end
        got++;
        if (gob == nocb - 1) begin gob = 0; gp++; end
        else gob++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; start = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R10", busy, 0);
    chk(in_ready == 1'b0, "R11", in_ready, 0);
    chk(out_valid == 1'b0, "R11", out_valid, 0);
    chk(sent == nbeats, "R11", sent, nbeats);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b0, "R1", in_ready, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    rst = 1'b0;
    // Idle: offered input must not be taken (R2)
    in_valid = 1'b1;
    in_data = '1;
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(in_ready == 1'b0, "R2", in_ready, 0);
      chk(out_valid == 1'b0, "R2", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    // ic, oc, width, height, weight mode, act mode, valid %, ready %, tag, poke
    run_case(32, 32, 1, 1, 1, 1, 100, 100, "R3", 0);   // all +1, max sum 480
    run_case(32, 32, 1, 1, 2, 0, 100, 100, "R3", 0);   // all -1, negative sums
    run_case(464, 32, 1, 1, 1, 1, 100, 100, "R3", 0);  // 6960 wraps in 13 bits
    run_case(96, 96, 2, 2, 0, 0, 100, 100, "R4", 0);   // multi-block accumulation
    run_case(64, 96, 2, 1, 0, 0, 100, 100, "R6", 0);   // block addressing
    run_case(70, 64, 1, 2, 0, 0, 100, 100, "R5", 0);   // input ordering
    run_case(40, 45, 2, 3, 0, 0, 100, 100, "R7", 0);   // partial blocks both sides
    run_case(70, 64, 3, 2, 0, 0, 60, 50, "R9", 1);     // backpressure and stray start
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule